// File: doc/BRIEF.md
# Maskable Interrupt Status and Clear Unit

This block gathers single-cycle event pulses from a USB controller core into a sticky status register, gates that register with a software-written enable register, and drives one registered, active-high interrupt request. Both registers sit on a simple internal register bus. A read of the status location returns the pending flags. A write to the same location is a clear mask: every bit written as one is cleared, and bits written as zero are left as they are.

The event set is fixed, and some bit positions are unused. Bit 0 marks transfer completion on buffer set A and bit 1 marks transfer completion on buffer set B. Bit 4 marks the frame-start timer. Bit 5 marks a device insertion or removal, and bit 6 marks device detection or resume. Bits 2, 3 and 7 are unused. A flag latches whether or not its event is enabled; the enable bits only gate the request.

The request line is driven by a two-state machine. It stays in state `IRQ_IDLE` while no enabled flag is pending. It takes the transition `RAISE` to `IRQ_ACTIVE` on the first clock edge at which an enabled flag is pending. It takes the transition `DROP` back to `IRQ_IDLE` on the first edge at which none is pending. At any other edge it holds its state.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the status register and the enable register both read 00h and `irq_o` is low.
- R2: An event pulse on `evt_i` bit 0, 1, 4, 5 or 6 sets the status flag at the same bit position on the next clock edge. The flag then stays set until it is cleared.
- R3: A flag latches on its event even when its enable bit is zero. In that case `irq_o` stays low.
- R4: A bus write to address 0Dh clears each status flag whose data bit is one. Flags whose data bit is zero are unchanged.
- R5: Bits 2, 3 and 7 of both registers always read zero. Events and writes on those bit positions have no effect.
- R6: If an event and a clear hit the same flag in the same cycle, the event wins and the flag stays set.
- R7: A bus write to address 06h loads the enable register, and a read of 06h returns it. No other write changes it.
- R8: `irq_o` goes high one cycle after the AND of status and enable first becomes nonzero.
- R9: `irq_o` goes low one cycle after the last enabled pending flag is cleared or masked off.
- R10: Reads of any address other than 06h and 0Dh return 00h. Writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event pulses, one per status bit position |
| bus_addr_i | input | 8 | Register bus address |
| bus_wr_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request, registered, active high |

## Verification
A flag that is lost or stuck shows on the status read-back in the cycle right after the faulty edge. If that flag is enabled, it also shows on `irq_o` one cycle later. A wrong enable bit or a wrong request state can only be seen at the ports while the matching flag is pending. For that reason the bench drives long random runs in which events, clears and enable changes overlap, including events that arrive in the same cycle as a clear. Every cycle it compares the read data and `irq_o` against a cycle-accurate model.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
    localparam int unsigned REG_W = 8;
    localparam int unsigned ADR_W = 8;

    localparam int unsigned EV_XFER_A  = 0;
    localparam int unsigned EV_XFER_B  = 1;
    localparam int unsigned EV_FRAME   = 4;
    localparam int unsigned EV_ATTACH  = 5;
    localparam int unsigned EV_WAKE    = 6;

    localparam logic [REG_W-1:0] LIVE_BITS =
        (REG_W'(1) << EV_XFER_A) | (REG_W'(1) << EV_XFER_B) |
        (REG_W'(1) << EV_FRAME)  | (REG_W'(1) << EV_ATTACH) |
        (REG_W'(1) << EV_WAKE);

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int unsigned    W     = 8,
    parameter logic [W-1:0]   LIVE  = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic flag_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)        flag_q <= 1'b0;
                else if (set_i[i])  flag_q <= 1'b1;   // set beats clear
                else if (clr_i[i])  flag_q <= 1'b0;
            end
            assign flags_o[i] = flag_q;
        end else begin : g_hole
            assign flags_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned    W     = 8,
    parameter logic [W-1:0]   LIVE  = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     mask_q <= '0;
        else if (load_i) mask_q <= data_i & LIVE;
    end
    assign mask_o = mask_q;
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_unit_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_i,
    output logic req_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= IRQ_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend_i)  state_d = IRQ_ACTIVE;  // RAISE
            IRQ_ACTIVE: if (!pend_i) state_d = IRQ_IDLE;    // DROP
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        req_o = (state_q == IRQ_ACTIVE);
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_unit_pkg::*;
#(
    parameter int unsigned          DW        = REG_W,
    parameter int unsigned          AW        = ADR_W,
    parameter logic [AW-1:0]        EN_ADDR   = 8'h06,
    parameter logic [AW-1:0]        STAT_ADDR = 8'h0D,
    parameter logic [DW-1:0]        LIVE      = LIVE_BITS
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] evt_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_wr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o
);
    logic          hit_en, hit_stat;
    logic [DW-1:0] clr_mask, set_mask;
    logic [DW-1:0] status_q, enable_q;
    logic          pend;

    assign hit_en   = (bus_addr_i == EN_ADDR);
    assign hit_stat = (bus_addr_i == STAT_ADDR);
    assign clr_mask = (bus_wr_i && hit_stat) ? bus_wdata_i : '0;
    assign set_mask = evt_i & LIVE;

    irq_evt_latch #(.W(DW), .LIVE(LIVE)) u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_mask),
        .clr_i  (clr_mask),
        .flags_o(status_q)
    );

    irq_mask_reg #(.W(DW), .LIVE(LIVE)) u_mask (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (bus_wr_i && hit_en),
        .data_i (bus_wdata_i),
        .mask_o (enable_q)
    );

    assign pend = |(status_q & enable_q);

    irq_req_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (pend),
        .req_o  (irq_o)
    );

    always_comb begin
        if (hit_stat)    bus_rdata_o = status_q;
        else if (hit_en) bus_rdata_o = enable_q;
        else             bus_rdata_o = '0;
    end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int unsigned   DW        = 8,
    parameter int unsigned   AW        = 8,
    parameter logic [AW-1:0] EN_ADDR   = 8'h06,
    parameter logic [AW-1:0] STAT_ADDR = 8'h0D,
    parameter logic [DW-1:0] LIVE      = '1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [DW-1:0] evt_i,
    input logic [AW-1:0] bus_addr_i,
    input logic          bus_wr_i,
    input logic [DW-1:0] bus_wdata_i,
    input logic [DW-1:0] status_q,
    input logic [DW-1:0] enable_q,
    input logic          irq_o
);
    p_holes_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_q | enable_q) & ~LIVE) == '0);

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |(evt_i & LIVE) |=> ((status_q & $past(evt_i & LIVE)) == $past(evt_i & LIVE)));

    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == STAT_ADDR)
        |=> ((status_q & $past(bus_wdata_i & ~evt_i)) == '0));

    p_enable_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_wr_i && bus_addr_i == EN_ADDR) |=> $stable(enable_q));

    p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(status_q & enable_q)) |=> irq_o);

    p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(status_q & enable_q)) |=> !irq_o);
endmodule

bind irq_status_unit irq_status_unit_chk #(
    .DW(DW), .AW(AW), .EN_ADDR(EN_ADDR), .STAT_ADDR(STAT_ADDR), .LIVE(LIVE)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_wdata_i(bus_wdata_i),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .irq_o      (irq_o)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    localparam logic [7:0] LIVE = 8'h73;
    localparam logic [7:0] A_EN = 8'h06;
    localparam logic [7:0] A_ST = 8'h0D;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] evt_i = '0;
    logic [7:0] bus_addr_i = '0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       irq_o;

    always #2 clk_i = ~clk_i;

    irq_status_unit dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [7:0] rdata;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_st = '0, m_en = '0;
    logic       m_irq = 1'b0;

    task automatic step(input logic [7:0] ev, input logic wr,
                        input logic [7:0] addr, input logic [7:0] wd, input string tag);
        exp_t e;
        @(negedge clk_i);
        evt_i = ev; bus_wr_i = wr; bus_addr_i = addr; bus_wdata_i = wd;
        e.rdata = (addr == A_ST) ? m_st : (addr == A_EN) ? m_en : 8'h00;
        e.irq   = m_irq;
        e.tag   = tag;
        exp_q.push_back(e);
        m_irq = |(m_st & m_en);
        m_st  = (m_st & ~((wr && addr == A_ST) ? wd : 8'h00)) | (ev & LIVE);
        if (wr && addr == A_EN) m_en = wd & LIVE;
    endtask

    task automatic rd(input logic [7:0] addr, input string tag);
        step(8'h00, 1'b0, addr, 8'h00, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk_i);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (bus_rdata_o !== e.rdata) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata_o, e.rdata);
                end
                checks++;
                if (irq_o !== e.irq) begin
                    failures++;
                    $display("FAIL %s irq actual=%b expected=%b", e.tag, irq_o, e.irq);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        rd(A_ST, "R1"); rd(A_EN, "R1");
        step(8'h01, 0, A_ST, 0, "R2"); rd(A_ST, "R2");
        step(8'h40, 0, A_ST, 0, "R2"); rd(A_ST, "R2"); rd(A_ST, "R2");
        rd(A_ST, "R3");                     // enable 0: irq low
        step(8'h00, 1, A_ST, 8'h01, "R4"); rd(A_ST, "R4");
        step(8'h10, 1, A_ST, 8'h10, "R6"); rd(A_ST, "R6");
        step(8'h8C, 0, A_ST, 0, "R5"); rd(A_ST, "R5");
        step(8'h00, 1, A_ST, 8'h8C, "R5"); rd(A_ST, "R5");
        step(8'h00, 1, A_EN, 8'hFF, "R7"); rd(A_EN, "R7");
        rd(A_EN, "R8"); rd(A_EN, "R8");
        step(8'h00, 1, A_ST, 8'hFF, "R9"); rd(A_ST, "R9"); rd(A_ST, "R9");
        step(8'h00, 1, 8'h20, 8'hFF, "R10"); rd(8'h20, "R10"); rd(A_EN, "R10"); rd(A_ST, "R10");
        step(8'h00, 1, A_EN, 8'h02, "R7");
        step(8'h02, 0, A_EN, 0, "R8"); rd(A_EN, "R8"); rd(A_ST, "R8");
        step(8'h00, 1, A_EN, 8'h00, "R9"); rd(A_EN, "R9"); rd(A_EN, "R9"); rd(A_ST, "R3");
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] ev, wd, ad;
            logic wr;
            int sel;
            ev  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            wd  = 8'($urandom);
            wr  = ($urandom_range(0, 2) == 0);
            sel = $urandom_range(0, 9);
            ad  = (sel < 5) ? A_ST : (sel < 8) ? A_EN : 8'($urandom);
            step(ev, wr, ad, wd, "R2 R4 R6 R8 R9 random");
        end
        rd(A_ST, "R2");
        @(negedge clk_i);
        @(negedge clk_i);
        #2;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule